// File: doc/BRIEF.md
# Coprocessor Multiply Unit

This block is a multi-cycle integer multiplier that sits beside a small RISC-V core on its coprocessor handshake. When the core meets an instruction it cannot execute, it raises a valid strobe and puts the raw instruction word and both source register values on the shared bus. The unit decodes the word itself. It claims only the four RV32M multiply forms. It raises a hold-off signal one cycle later, so the core does not flag the instruction as illegal. It then forms the 64-bit product one multiplier bit per cycle and returns the selected 32-bit half together with a one-cycle write strobe and completion pulse.

The control is a four-state machine:
- `ST_IDLE` moves to `ST_BUSY` when valid is high and the word is claimed (transition *accept*).
- `ST_BUSY` loops for 32 iterations and moves to `ST_DONE` on the last one (transition *finish*). It drops back to `ST_IDLE` if valid falls (transition *abort*).
- `ST_DONE` lasts one cycle and always moves to `ST_SETTLE` (transition *retire*).
- `ST_SETTLE` returns to `ST_IDLE` once valid is seen low (transition *release*). This stops the same instruction from being claimed twice.

Top module: `copro_mul`

## Requirements
- R1: A word is claimed only when bits 6:0 are 0110011, bits 31:25 are 0000001 and bit 14 is 0. Any other word leaves hold and done low.
- R2: Function code 000 in bits 14:12 returns bits 31:0 of the product of the two operands.
- R3: Function code 001 returns bits 63:32 of the product with both operands treated as signed.
- R4: Function code 010 returns bits 63:32 of the product with rs1 signed and rs2 unsigned.
- R5: Function code 011 returns bits 63:32 of the product with both operands unsigned.
- R6: Hold rises in the cycle after the accepting edge. It stays high until the last iteration and is low in the cycle where done is high.
- R7: Done and the write strobe are high together for exactly one cycle, starting 32 clock edges after the accepting edge.
- R8: If valid is low at any clock edge while the unit is busy, the operation is dropped. Hold falls and done is never raised for it.
- R9: After done, no new word is claimed until valid has been sampled low at least once.
- R10: After reset, and in every cycle where done is low, hold, done and the write strobe are low and the result bus reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_valid | input | 1 | Host offers an instruction |
| cp_insn | input | 32 | Undecoded instruction word |
| cp_rs1 | input | 32 | First source operand value |
| cp_rs2 | input | 32 | Second source operand value |
| cp_wr | output | 1 | Write result to destination register |
| cp_rd | output | 32 | Result value |
| cp_hold | output | 1 | Instruction claimed, still computing |
| cp_done | output | 1 | Result ready this cycle |

## Verification
The bench targets operand extremes: the most negative value, all-ones and zero, in each of the four signedness modes. A design that mixed up sign extension or the final negative-weight step would return a wrong high word only for negative operands. Words that differ from a claimed one in a single field check that look-alike words are rejected; a loose decoder would raise hold on a divide. Aborting mid-run and holding valid high after done exercise the abort and settle paths. A missing abort would pulse done with no request behind it. A missing settle state would run the same multiply a second time.

// File: rtl/mulcp_pkg.sv
package mulcp_pkg;
    typedef enum logic [1:0] {
        OP_MUL    = 2'b00,
        OP_MULH   = 2'b01,
        OP_MULHSU = 2'b10,
        OP_MULHU  = 2'b11
    } mul_op_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_DONE,
        ST_SETTLE
    } mul_state_t;

    localparam logic [6:0] OPC_REG_REG = 7'b0110011;
    localparam logic [6:0] F7_MULDIV   = 7'b0000001;
endpackage

// File: rtl/mulcp_decode.sv
module mulcp_decode
    import mulcp_pkg::*;
(
    input  logic [31:0] insn,
    output logic        hit,
    output mul_op_t     op,
    output logic        a_signed,
    output logic        b_signed,
    output logic        sel_hi
);
    logic unused_fields;

    always_comb begin
        unused_fields = ^{insn[24:15], insn[11:7]};
        hit      = (insn[6:0] == OPC_REG_REG) && (insn[31:25] == F7_MULDIV) && !insn[14];
        op       = mul_op_t'(insn[13:12]);
        a_signed = (op == OP_MULH) || (op == OP_MULHSU);
        b_signed = (op == OP_MULH);
        sel_hi   = (op != OP_MUL);
    end
endmodule

// File: rtl/mulcp_datapath.sv
module mulcp_datapath #(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic              last,
    output logic [2*XLEN-1:0] product
);
    localparam int PW = 2 * XLEN;
    localparam int CW = $clog2(XLEN);
    localparam logic [CW-1:0] CNT_LAST = CW'(XLEN - 1);

    logic [PW-1:0]   acc_q;
    logic [PW-1:0]   mcand_q;
    logic [XLEN-1:0] mplier_q;
    logic [CW-1:0]   cnt_q;
    logic            neg_top_q;
    logic [PW-1:0]   mcand_ext;
    logic [PW-1:0]   addend;

    always_comb begin
        mcand_ext = {{XLEN{a_signed & op_a[XLEN-1]}}, op_a};
        addend    = mplier_q[0] ? mcand_q : '0;
        last      = (cnt_q == CNT_LAST);
        product   = acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            mcand_q   <= '0;
            mplier_q  <= '0;
            cnt_q     <= '0;
            neg_top_q <= 1'b0;
        end else if (load) begin
            acc_q     <= '0;
            mcand_q   <= mcand_ext;
            mplier_q  <= op_b;
            cnt_q     <= '0;
            neg_top_q <= b_signed;
        end else if (step) begin
            // top multiplier bit carries weight -2^(XLEN-1) when signed
            if (last && neg_top_q) acc_q <= acc_q - addend;
            else                   acc_q <= acc_q + addend;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            cnt_q    <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/copro_mul.sv
module copro_mul
    import mulcp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cp_valid,
    input  logic [31:0]     cp_insn,
    input  logic [XLEN-1:0] cp_rs1,
    input  logic [XLEN-1:0] cp_rs2,
    output logic            cp_wr,
    output logic [XLEN-1:0] cp_rd,
    output logic            cp_hold,
    output logic            cp_done
);
    localparam int PW = 2 * XLEN;

    mul_state_t    state_q, state_d;
    mul_op_t       dec_op;
    logic          dec_hit, dec_as, dec_bs, dec_hi;
    logic          sel_hi_q;
    logic          accept, step, last;
    logic [PW-1:0] product;

    mulcp_decode u_dec (
        .insn     (cp_insn),
        .hit      (dec_hit),
        .op       (dec_op),
        .a_signed (dec_as),
        .b_signed (dec_bs),
        .sel_hi   (dec_hi)
    );

    assign accept = (state_q == ST_IDLE) && cp_valid && dec_hit;
    assign step   = (state_q == ST_BUSY) && cp_valid;

    mulcp_datapath #(.XLEN(XLEN)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (step),
        .op_a     (cp_rs1),
        .op_b     (cp_rs2),
        .a_signed (dec_as),
        .b_signed (dec_bs),
        .last     (last),
        .product  (product)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_BUSY;
            ST_BUSY:   if (!cp_valid) state_d = ST_IDLE;
                       else if (last) state_d = ST_DONE;
            ST_DONE:   state_d = ST_SETTLE;
            ST_SETTLE: if (!cp_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sel_hi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) sel_hi_q <= dec_hi;
        end
    end

    always_comb begin
        cp_hold = 1'b0;
        cp_done = 1'b0;
        cp_wr   = 1'b0;
        cp_rd   = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_BUSY:   cp_hold = 1'b1;
            ST_DONE: begin
                cp_done = 1'b1;
                cp_wr   = 1'b1;
                cp_rd   = sel_hi_q ? product[PW-1:XLEN] : product[XLEN-1:0];
            end
            ST_SETTLE: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/mulcp_checker.sv
module mulcp_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cp_valid,
    input logic            cp_wr,
    input logic [XLEN-1:0] cp_rd,
    input logic            cp_hold,
    input logic            cp_done
);
    AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) cp_wr == cp_done); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) cp_done |=> !cp_done); // R7
    AST_HOLD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cp_hold && cp_done)); // R6
    AST_DONE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) cp_done |-> $past(cp_hold)); // R6
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n) (cp_hold && !cp_valid) |=> (!cp_done && !cp_hold)); // R8
    AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) $rose(cp_hold) |-> $past(cp_valid)); // R1
    AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cp_done |-> (cp_rd == '0)); // R10
endmodule

bind copro_mul mulcp_checker #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cp_valid (cp_valid),
    .cp_wr    (cp_wr),
    .cp_rd    (cp_rd),
    .cp_hold  (cp_hold),
    .cp_done  (cp_done)
);

// File: tb/copro_mul_bench.sv
`timescale 1ns/1ps
module copro_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_valid = 1'b0;
    logic [31:0] cp_insn = '0;
    logic [31:0] cp_rs1 = '0;
    logic [31:0] cp_rs2 = '0;
    logic        cp_wr, cp_hold, cp_done;
    logic [31:0] cp_rd;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string scen = "R10";

    // reference model state: 0 idle, 1 busy, 2 done, 3 settle
    int          m_st = 0;
    int          m_n = 0;
    int          m_op = 0;
    logic [31:0] m_res = '0;

    always #4 clk = ~clk;

    copro_mul u_copro_mul (
        .clk(clk), .rst_n(rst_n), .cp_valid(cp_valid), .cp_insn(cp_insn),
        .cp_rs1(cp_rs1), .cp_rs2(cp_rs2), .cp_wr(cp_wr), .cp_rd(cp_rd),
        .cp_hold(cp_hold), .cp_done(cp_done)
    );

    function automatic logic [31:0] enc(int f3);
        return {7'b0000001, 5'd3, 5'd2, 3'(f3), 5'd1, 7'b0110011};
    endfunction

    function automatic bit claimed(logic [31:0] w);
        return (w[6:0] == 7'b0110011) && (w[31:25] == 7'b0000001) && !w[14];
    endfunction

    function automatic logic [31:0] ref_mul(int op, logic [31:0] a, logic [31:0] b);
        longint sa, sb, p;
        sa = (op == 1 || op == 2) ? longint'($signed(a)) : longint'({32'b0, a});
        sb = (op == 1)            ? longint'($signed(b)) : longint'({32'b0, b});
        p = sa * sb;
        return (op == 0) ? p[31:0] : p[63:32];
    endfunction

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (!rst_n) begin
            m_st = 0; m_n = 0;
        end else begin
            case (m_st)
                0: if (cp_valid && claimed(cp_insn)) begin
                       m_st = 1; m_n = 0; m_op = int'(cp_insn[13:12]);
                       m_res = ref_mul(m_op, cp_rs1, cp_rs2);
                   end
                1: if (!cp_valid) m_st = 0;
                   else if (m_n == 31) m_st = 2;
                   else m_n = m_n + 1;
                2: m_st = 3;
                default: if (!cp_valid) m_st = 0;
            endcase
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s (scenario %s) t=%0t actual=%h expected=%h", req, scen, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #2;
        begin
            logic exp_hold, exp_done;
            logic [31:0] exp_rd;
            string rtag;
            exp_hold = (m_st == 1);
            exp_done = (m_st == 2);
            exp_rd   = exp_done ? m_res : 32'h0;
            rtag = !exp_done ? "R10" : (m_op == 0) ? "R2" : (m_op == 1) ? "R3" : (m_op == 2) ? "R4" : "R5";
            chk(cp_hold == exp_hold, "R6", 32'(cp_hold), 32'(exp_hold));
            chk(cp_done == exp_done, "R7", 32'(cp_done), 32'(exp_done));
            chk(cp_wr == exp_done, "R7", 32'(cp_wr), 32'(exp_done));
            chk(cp_rd == exp_rd, rtag, cp_rd, exp_rd);
        end
    end

    task automatic issue(int f3, logic [31:0] a, logic [31:0] b, int linger);
        @(negedge clk);
        cp_valid = 1'b1; cp_insn = enc(f3); cp_rs1 = a; cp_rs2 = b;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cp_done) break;
        end
        for (int i = 0; i < linger; i++) @(negedge clk);
        cp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic raw(logic [31:0] w, int len);
        @(negedge clk);
        cp_valid = 1'b1; cp_insn = w; cp_rs1 = 32'h1234; cp_rs2 = 32'h5678;
        for (int i = 0; i < len; i++) @(negedge clk);
        cp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        scen = "R10";
        chk(!cp_hold && !cp_done && !cp_wr && cp_rd == 0, "R10", cp_rd, 32'h0);
        rst_n = 1'b1;
        scen = "R2";
        issue(0, 32'd7, 32'd6, 0);
        issue(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue(0, 32'h8000_0000, 32'd3, 0);
        scen = "R3";
        issue(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue(1, 32'h8000_0000, 32'h8000_0000, 0);
        issue(1, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        issue(1, 32'h1234_5678, 32'hFEDC_BA98, 0);
        scen = "R4";
        issue(2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue(2, 32'h8000_0000, 32'h8000_0000, 0);
        issue(2, 32'd5, 32'hFFFF_FFFF, 0);
        scen = "R5";
        issue(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue(3, 32'h8000_0000, 32'd2, 0);
        issue(3, 32'd0, 32'hDEAD_BEEF, 0);
        for (int k = 0; k < 12; k++) issue(k % 4, $urandom, $urandom, 0);
        scen = "R1";
        raw(enc(4), 20);                          // divide encoding
        raw(enc(0) ^ 32'h0000_0001, 20);          // wrong opcode
        raw(enc(1) | 32'h4000_0000, 20);          // wrong funct7
        raw(enc(0), 1);                           // claimed, aborted at once
        scen = "R8";
        @(negedge clk);
        raw(enc(3), 10);
        repeat (40) @(negedge clk);
        scen = "R9";
        issue(1, 32'hFFFF_FFF0, 32'd9, 4);        // valid lingers after done
        issue(2, 32'hC000_0001, 32'h8000_0001, 0);
        scen = "R7";
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog (scenario %s) actual=%0d expected=%0d", scen, cycles, 20000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule